// File: doc/BRIEF.md
# Satellite Error Capture Registers

This block collects error events on a satellite node into sticky status bits that a processor reads. It has two groups. The real-time I/O group records sequence, collision and busy errors, each with the channel number that caused it. The protocol group records four link errors. One of them, the write underflow, also records its channel, the event timestamp and the timestamp counter value. Each error arrives as a single-cycle pulse, with its detail values valid in that same cycle.

Software reads a status mask first, then the detail registers for the bits that are set. It then writes a mask back, and every bit that is 1 in that mask is cleared. Each sticky bit is a small two-state machine. In `SLOT_CLEAR` an error pulse takes it to `SLOT_HELD`, and the detail register loads on that transition. In `SLOT_HELD` the bit stays set until a clear write arrives without a coincident event. Only that condition takes it back to `SLOT_CLEAR`. A clear write that arrives together with an event leaves the bit in `SLOT_HELD`.

Top module: `sat_err_capture`

## Requirements
- R1: After reset, every status bit and every detail output is zero.
- R2: In the real-time I/O status, bit 0 is sequence error, bit 1 is collision and bit 2 is busy. A pulse on an error input sets its bit at the first clock edge after the pulse.
- R3: When a real-time I/O bit goes from clear to set, its channel output takes the channel value presented with that pulse.
- R4: While a bit stays set, further events of the same kind do not change its detail outputs.
- R5: A real-time I/O clear write clears each status bit whose mask bit is 1 at the next edge. Bits whose mask bit is 0 keep their value. Detail outputs are not changed by the clear.
- R6: An event that arrives in the same cycle as a clear write for its bit leaves the bit set. If the bit was already set, the detail is kept.
- R7: In the protocol status, bit 0 is unknown packet type, bit 1 is packet truncation, bit 2 is write underflow and bit 3 is write overflow. Each bit sets at the edge after its pulse.
- R8: When the underflow bit goes from clear to set, three outputs load from the values presented with the pulse. The 64-bit channel output takes the channel, zero-extended. The event timestamp output takes the event timestamp, and the counter output takes the counter value.
- R9: A protocol clear write with the value just read clears exactly the bits that were set.
- R10: A set bit stays set through any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_err_i | input | 1 | Sequence error pulse |
| seq_chan_i | input | CHAN_W | Channel of the sequence error |
| coll_err_i | input | 1 | Collision pulse |
| coll_chan_i | input | CHAN_W | Channel of the collision |
| busy_err_i | input | 1 | Busy error pulse |
| busy_chan_i | input | CHAN_W | Channel of the busy error |
| unk_type_i | input | 1 | Unknown packet type pulse |
| trunc_i | input | 1 | Packet truncation pulse |
| uf_err_i | input | 1 | Write underflow pulse |
| uf_chan_i | input | CHAN_W | Channel of the underflow |
| uf_event_ts_i | input | TS_W | Event timestamp of the underflow |
| uf_counter_ts_i | input | TS_W | Timestamp counter at the underflow |
| ovf_err_i | input | 1 | Write overflow pulse |
| rtio_clr_we_i | input | 1 | Real-time I/O clear write strobe |
| rtio_clr_mask_i | input | 3 | Real-time I/O bits to clear |
| proto_clr_we_i | input | 1 | Protocol clear write strobe |
| proto_clr_mask_i | input | 4 | Protocol bits to clear |
| rtio_status_o | output | 3 | Real-time I/O sticky status |
| seq_chan_o | output | CHAN_W | Latched sequence error channel |
| coll_chan_o | output | CHAN_W | Latched collision channel |
| busy_chan_o | output | CHAN_W | Latched busy channel |
| proto_status_o | output | 4 | Protocol sticky status |
| uf_chan_o | output | TS_W | Latched underflow channel, zero-extended |
| uf_event_ts_o | output | TS_W | Latched underflow event timestamp |
| uf_counter_ts_o | output | TS_W | Latched underflow counter value |

## Verification
The assertions assume that an error pulse and its detail values are valid in the same cycle. They also assume that a clear write lasts one cycle and that its mask is sampled only while the strobe is high. The properties are relative to the edge after each input, so pulses may come back to back, in any combination, and overlap with clears. The random stimulus drives pulses, details and clear writes independently in every cycle, including the case where an event and a clear for the same bit coincide. Directed sequences cover the load-once rule and the write-back of the value just read.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
    localparam int RTIO_NB  = 3;
    localparam int PROTO_NB = 4;

    // protocol status bit positions
    localparam int P_UNKNOWN = 0;
    localparam int P_TRUNC   = 1;
    localparam int P_UNDER   = 2;
    localparam int P_OVER    = 3;

    typedef enum logic {
        SLOT_CLEAR = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/flag_slot.sv
module flag_slot
    import errcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clear_i,
    output logic flag_o
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_CLEAR: if (event_i)              state_d = SLOT_HELD;
            SLOT_HELD:  if (clear_i && !event_i)  state_d = SLOT_CLEAR;
            default:                              state_d = SLOT_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == SLOT_HELD);
    end
endmodule

// File: rtl/err_slot.sv
module err_slot #(
    parameter int DETAIL_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                event_i,
    input  logic [DETAIL_W-1:0] detail_i,
    input  logic                clear_i,
    output logic                flag_o,
    output logic [DETAIL_W-1:0] detail_o
);
    logic flag;
    logic load;

    flag_slot u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .event_i(event_i),
        .clear_i(clear_i),
        .flag_o (flag)
    );

    // details load only on the clear-to-set transition
    assign load = event_i && !flag;

    always_ff @(posedge clk) begin
        if (!rst_n)    detail_o <= '0;
        else if (load) detail_o <= detail_i;
    end

    assign flag_o = flag;
endmodule

// File: rtl/sat_err_capture.sv
module sat_err_capture
    import errcap_pkg::*;
#(
    parameter int CHAN_W = 16,
    parameter int TS_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_err_i,
    input  logic [CHAN_W-1:0] seq_chan_i,
    input  logic              coll_err_i,
    input  logic [CHAN_W-1:0] coll_chan_i,
    input  logic              busy_err_i,
    input  logic [CHAN_W-1:0] busy_chan_i,
    input  logic              unk_type_i,
    input  logic              trunc_i,
    input  logic              uf_err_i,
    input  logic [CHAN_W-1:0] uf_chan_i,
    input  logic [TS_W-1:0]   uf_event_ts_i,
    input  logic [TS_W-1:0]   uf_counter_ts_i,
    input  logic              ovf_err_i,
    input  logic              rtio_clr_we_i,
    input  logic [2:0]        rtio_clr_mask_i,
    input  logic              proto_clr_we_i,
    input  logic [3:0]        proto_clr_mask_i,
    output logic [2:0]        rtio_status_o,
    output logic [CHAN_W-1:0] seq_chan_o,
    output logic [CHAN_W-1:0] coll_chan_o,
    output logic [CHAN_W-1:0] busy_chan_o,
    output logic [3:0]        proto_status_o,
    output logic [TS_W-1:0]   uf_chan_o,
    output logic [TS_W-1:0]   uf_event_ts_o,
    output logic [TS_W-1:0]   uf_counter_ts_o
);
    localparam int UF_W  = 3 * TS_W;
    localparam int PAD_W = TS_W - CHAN_W;

    logic [RTIO_NB-1:0]             rtio_evt;
    logic [RTIO_NB-1:0]             rtio_clr;
    logic [RTIO_NB-1:0][CHAN_W-1:0] rtio_chan_in;
    logic [RTIO_NB-1:0][CHAN_W-1:0] rtio_chan_q;
    logic [PROTO_NB-1:0]            proto_evt;
    logic [PROTO_NB-1:0]            proto_clr;
    logic [UF_W-1:0]                uf_detail_in;
    logic [UF_W-1:0]                uf_detail_q;

    assign rtio_evt     = {busy_err_i, coll_err_i, seq_err_i};
    assign rtio_chan_in = {busy_chan_i, coll_chan_i, seq_chan_i};
    assign rtio_clr     = {RTIO_NB{rtio_clr_we_i}} & rtio_clr_mask_i;

    assign proto_evt    = {ovf_err_i, uf_err_i, trunc_i, unk_type_i};
    assign proto_clr    = {PROTO_NB{proto_clr_we_i}} & proto_clr_mask_i;
    assign uf_detail_in = {{PAD_W{1'b0}}, uf_chan_i, uf_event_ts_i, uf_counter_ts_i};

    for (genvar i = 0; i < RTIO_NB; i++) begin : g_rtio
        err_slot #(.DETAIL_W(CHAN_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .event_i (rtio_evt[i]),
            .detail_i(rtio_chan_in[i]),
            .clear_i (rtio_clr[i]),
            .flag_o  (rtio_status_o[i]),
            .detail_o(rtio_chan_q[i])
        );
    end

    for (genvar j = 0; j < PROTO_NB; j++) begin : g_proto
        if (j == P_UNDER) begin : g_detail
            err_slot #(.DETAIL_W(UF_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .event_i (proto_evt[j]),
                .detail_i(uf_detail_in),
                .clear_i (proto_clr[j]),
                .flag_o  (proto_status_o[j]),
                .detail_o(uf_detail_q)
            );
        end else begin : g_plain
            flag_slot u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .event_i(proto_evt[j]),
                .clear_i(proto_clr[j]),
                .flag_o (proto_status_o[j])
            );
        end
    end

    assign seq_chan_o      = rtio_chan_q[0];
    assign coll_chan_o     = rtio_chan_q[1];
    assign busy_chan_o     = rtio_chan_q[2];
    assign uf_chan_o       = uf_detail_q[3*TS_W-1:2*TS_W];
    assign uf_event_ts_o   = uf_detail_q[2*TS_W-1:TS_W];
    assign uf_counter_ts_o = uf_detail_q[TS_W-1:0];
endmodule

// File: rtl/sat_err_capture_chk.sv
module sat_err_capture_chk #(
    parameter int CHAN_W = 16,
    parameter int TS_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_err_i,
    input logic [CHAN_W-1:0] seq_chan_i,
    input logic              coll_err_i,
    input logic              busy_err_i,
    input logic              uf_err_i,
    input logic [TS_W-1:0]   uf_event_ts_i,
    input logic              rtio_clr_we_i,
    input logic [2:0]        rtio_clr_mask_i,
    input logic              proto_clr_we_i,
    input logic [3:0]        proto_clr_mask_i,
    input logic [2:0]        rtio_status_o,
    input logic [CHAN_W-1:0] seq_chan_o,
    input logic [3:0]        proto_status_o,
    input logic [TS_W-1:0]   uf_event_ts_o
);
    // R2: error pulses set their bit at the next edge
    a_r2_seq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_i |=> rtio_status_o[0]);
    a_r2_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        coll_err_i |=> rtio_status_o[1]);
    a_r2_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err_i |=> rtio_status_o[2]);

    // R3: channel loaded on clear-to-set
    a_r3_seq_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtio_status_o[0] && seq_err_i) |=> (seq_chan_o == $past(seq_chan_i)));

    // R4: detail frozen while set
    a_r4_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rtio_status_o[0] |=> $stable(seq_chan_o));
    a_r4_uf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        proto_status_o[2] |=> $stable(uf_event_ts_o));

    // R5: clear without event drops the bit
    a_r5_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rtio_clr_we_i && rtio_clr_mask_i[0] && !seq_err_i) |=> !rtio_status_o[0]);

    // R6: event beats a simultaneous clear
    a_r6_seq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rtio_clr_we_i && rtio_clr_mask_i[0] && seq_err_i) |=> rtio_status_o[0]);

    // R8: underflow details loaded on clear-to-set
    a_r8_uf_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!proto_status_o[2] && uf_err_i) |=> (uf_event_ts_o == $past(uf_event_ts_i)));

    // R10: sticky while no clear is written
    a_r10_rtio_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rtio_status_o[1] && !rtio_clr_we_i) |=> rtio_status_o[1]);
    a_r10_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_status_o[3] && !(proto_clr_we_i && proto_clr_mask_i[3])) |=> proto_status_o[3]);
endmodule

bind sat_err_capture sat_err_capture_chk #(.CHAN_W(CHAN_W), .TS_W(TS_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .seq_err_i       (seq_err_i),
    .seq_chan_i      (seq_chan_i),
    .coll_err_i      (coll_err_i),
    .busy_err_i      (busy_err_i),
    .uf_err_i        (uf_err_i),
    .uf_event_ts_i   (uf_event_ts_i),
    .rtio_clr_we_i   (rtio_clr_we_i),
    .rtio_clr_mask_i (rtio_clr_mask_i),
    .proto_clr_we_i  (proto_clr_we_i),
    .proto_clr_mask_i(proto_clr_mask_i),
    .rtio_status_o   (rtio_status_o),
    .seq_chan_o      (seq_chan_o),
    .proto_status_o  (proto_status_o),
    .uf_event_ts_o   (uf_event_ts_o)
);

// File: tb/tb_sat_err_capture.sv
module tb_sat_err_capture;
    localparam int CLK_PERIOD = 10;
    localparam int CHAN_W = 16;
    localparam int TS_W   = 64;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_err, coll_err, busy_err, unk_type, trunc, uf_err, ovf_err;
    logic [CHAN_W-1:0] seq_chan, coll_chan, busy_chan, uf_chan;
    logic [TS_W-1:0] uf_ev, uf_ct;
    logic rclr_we, pclr_we;
    logic [2:0] rclr_mask;
    logic [3:0] pclr_mask;
    logic [2:0] rtio_status;
    logic [CHAN_W-1:0] seq_chan_q, coll_chan_q, busy_chan_q;
    logic [3:0] proto_status;
    logic [TS_W-1:0] uf_chan_q, uf_ev_q, uf_ct_q;

    // reference model state
    logic [2:0] m_rtio;
    logic [CHAN_W-1:0] m_chan [3];
    logic [3:0] m_proto;
    logic [TS_W-1:0] m_uf_ch, m_uf_ev, m_uf_ct;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_err_capture #(.CHAN_W(CHAN_W), .TS_W(TS_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .seq_err_i(seq_err), .seq_chan_i(seq_chan),
        .coll_err_i(coll_err), .coll_chan_i(coll_chan),
        .busy_err_i(busy_err), .busy_chan_i(busy_chan),
        .unk_type_i(unk_type), .trunc_i(trunc),
        .uf_err_i(uf_err), .uf_chan_i(uf_chan),
        .uf_event_ts_i(uf_ev), .uf_counter_ts_i(uf_ct),
        .ovf_err_i(ovf_err),
        .rtio_clr_we_i(rclr_we), .rtio_clr_mask_i(rclr_mask),
        .proto_clr_we_i(pclr_we), .proto_clr_mask_i(pclr_mask),
        .rtio_status_o(rtio_status),
        .seq_chan_o(seq_chan_q), .coll_chan_o(coll_chan_q), .busy_chan_o(busy_chan_q),
        .proto_status_o(proto_status),
        .uf_chan_o(uf_chan_q), .uf_event_ts_o(uf_ev_q), .uf_counter_ts_o(uf_ct_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        seq_err = 0; coll_err = 0; busy_err = 0;
        unk_type = 0; trunc = 0; uf_err = 0; ovf_err = 0;
        rclr_we = 0; rclr_mask = 0; pclr_we = 0; pclr_mask = 0;
    endtask

    task automatic model_reset();
        m_rtio = 0; m_proto = 0;
        for (int i = 0; i < 3; i++) m_chan[i] = 0;
        m_uf_ch = 0; m_uf_ev = 0; m_uf_ct = 0;
    endtask

    // next state from requirements: load on clear-to-set, event beats clear
    task automatic model_step();
        logic [2:0] rev, rcl;
        logic [3:0] pev, pcl;
        logic [CHAN_W-1:0] ch [3];
        rev = {busy_err, coll_err, seq_err};
        rcl = rclr_we ? rclr_mask : 3'b0;
        pev = {ovf_err, uf_err, trunc, unk_type};
        pcl = pclr_we ? pclr_mask : 4'b0;
        ch[0] = seq_chan; ch[1] = coll_chan; ch[2] = busy_chan;
        for (int i = 0; i < 3; i++)
            if (rev[i] && !m_rtio[i]) m_chan[i] = ch[i];
        if (uf_err && !m_proto[2]) begin
            m_uf_ch = TS_W'(uf_chan);
            m_uf_ev = uf_ev;
            m_uf_ct = uf_ct;
        end
        m_rtio  = rev | (m_rtio & ~rcl);
        m_proto = pev | (m_proto & ~pcl);
    endtask

    // apply current inputs for one edge, then return at the next falling edge
    task automatic cycle();
        @(posedge clk);
        #1;
        model_step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "rtio_status (R2 R5)", TS_W'(rtio_status), TS_W'(m_rtio));
        chk(tag, "seq_chan (R3 R4)", TS_W'(seq_chan_q), TS_W'(m_chan[0]));
        chk(tag, "coll_chan (R3 R4)", TS_W'(coll_chan_q), TS_W'(m_chan[1]));
        chk(tag, "busy_chan (R3 R4)", TS_W'(busy_chan_q), TS_W'(m_chan[2]));
        chk(tag, "proto_status (R7 R9)", TS_W'(proto_status), TS_W'(m_proto));
        chk(tag, "uf_chan (R8)", uf_chan_q, m_uf_ch);
        chk(tag, "uf_event_ts (R8)", uf_ev_q, m_uf_ev);
        chk(tag, "uf_counter_ts (R8)", uf_ct_q, m_uf_ct);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] rd;
        void'($urandom(32'h5EED_1234));
        idle_inputs();
        seq_chan = 0; coll_chan = 0; busy_chan = 0; uf_chan = 0; uf_ev = 0; uf_ct = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "rtio_status", TS_W'(rtio_status), 0);
        chk("R1", "proto_status", TS_W'(proto_status), 0);
        chk("R1", "seq_chan", TS_W'(seq_chan_q), 0);
        chk("R1", "uf_event_ts", uf_ev_q, 0);

        // R2 R3: sequence error on channel 5
        seq_err = 1; seq_chan = 16'd5; cycle();
        chk("R2", "rtio_status after seq", TS_W'(rtio_status), 64'h1);
        chk("R3", "seq_chan", TS_W'(seq_chan_q), 64'd5);

        // R2: collision (bit 1) and busy (bit 2)
        coll_err = 1; coll_chan = 16'd9; busy_err = 1; busy_chan = 16'd3; cycle();
        chk("R2", "rtio_status after coll+busy", TS_W'(rtio_status), 64'h7);
        chk("R3", "coll_chan", TS_W'(coll_chan_q), 64'd9);
        chk("R3", "busy_chan", TS_W'(busy_chan_q), 64'd3);

        // R4: second sequence error keeps first channel
        seq_err = 1; seq_chan = 16'd7; cycle();
        chk("R4", "seq_chan kept", TS_W'(seq_chan_q), 64'd5);

        // R10: idle keeps bits
        repeat (4) cycle();
        chk("R10", "rtio_status sticky", TS_W'(rtio_status), 64'h7);

        // R5: clear collision only
        rclr_we = 1; rclr_mask = 3'b010; cycle();
        chk("R5", "rtio_status after clear 2", TS_W'(rtio_status), 64'h5);
        chk("R5", "coll_chan after clear", TS_W'(coll_chan_q), 64'd9);

        // R6: clear seq together with a new seq event
        rclr_we = 1; rclr_mask = 3'b001; seq_err = 1; seq_chan = 16'd11; cycle();
        chk("R6", "seq bit kept", TS_W'(rtio_status), 64'h5);
        chk("R6", "seq_chan kept", TS_W'(seq_chan_q), 64'd5);

        // R7: protocol bits one by one
        unk_type = 1; cycle();
        chk("R7", "unknown type bit0", TS_W'(proto_status), 64'h1);
        trunc = 1; cycle();
        chk("R7", "truncation bit1", TS_W'(proto_status), 64'h3);
        uf_err = 1; uf_chan = 16'd2; uf_ev = 64'd100; uf_ct = 64'd120; cycle();
        chk("R7", "underflow bit2", TS_W'(proto_status), 64'h7);
        chk("R8", "uf_chan", uf_chan_q, 64'd2);
        chk("R8", "uf_event_ts", uf_ev_q, 64'd100);
        chk("R8", "uf_counter_ts", uf_ct_q, 64'd120);
        ovf_err = 1; cycle();
        chk("R7", "overflow bit3", TS_W'(proto_status), 64'hF);

        // R9: write back the read value
        rd = proto_status;
        pclr_we = 1; pclr_mask = rd; cycle();
        chk("R9", "proto cleared by write-back", TS_W'(proto_status), 64'h0);
        compare_all("directed");

        // constrained random phase
        for (int n = 0; n < RAND_CYCLES; n++) begin
            seq_err  = ($urandom % 8) == 0;
            coll_err = ($urandom % 8) == 0;
            busy_err = ($urandom % 8) == 0;
            unk_type = ($urandom % 10) == 0;
            trunc    = ($urandom % 10) == 0;
            uf_err   = ($urandom % 6) == 0;
            ovf_err  = ($urandom % 10) == 0;
            seq_chan  = CHAN_W'($urandom);
            coll_chan = CHAN_W'($urandom);
            busy_chan = CHAN_W'($urandom);
            uf_chan   = CHAN_W'($urandom);
            uf_ev     = {$urandom, $urandom};
            uf_ct     = {$urandom, $urandom};
            rclr_we   = ($urandom % 5) == 0;
            rclr_mask = 3'($urandom);
            pclr_we   = ($urandom % 5) == 0;
            pclr_mask = (($urandom % 2) == 0) ? proto_status : 4'($urandom);
            cycle();
            compare_all("random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule